// File: doc/BRIEF.md
# Toggle-Handshake Word Synchronizer

This block moves one data word at a time from a source clock domain into a destination clock domain that has no fixed relation to it. When the source side accepts a load, it freezes the word in a holding register and inverts a single toggle flop. Only that toggle bit crosses the boundary. In the destination domain it passes through a two-flop synchronizer, and then an edge detector that reacts to either direction of change. The resulting one-cycle strobe copies the frozen word into the output register, and the block then raises a one-cycle valid.

The source side keeps a busy flag raised for a fixed number of source cycles after each accepted load. The holding register cannot change during that window. The window is sized from the fastest source clock and the slowest destination clock, so that it covers synchronizer latency plus the capture cycle. A load request that arrives while busy is high is dropped. The design also works when both domains run from one clock.

Top module: `xdom_word_bridge`

## Requirements
- R1: While a domain's synchronous reset is high, its outputs are zero: busy is 0 on the source side, and out_vld and out_word are 0 on the destination side. After reset no valid appears without an accepted load.
- R2: A load request sampled on a source edge while busy is 0 is accepted. The word is copied into the holding register, the toggle bit inverts, and busy is 1 from that edge on.
- R3: After an accepted load, busy stays 1 for exactly HOLD_CYC source cycles and then returns to 0.
- R4: A load request sampled while busy is 1 is ignored. Its word is never delivered and the toggle bit does not change.
- R5: The holding register does not change on any source edge at which busy is 1.
- R6: Each change of the synchronized toggle, rising or falling, gives exactly one capture strobe one destination cycle long. Every accepted load therefore produces exactly one delivery.
- R7: out_vld is 1 for exactly one destination cycle, the cycle after the capture strobe. In that cycle out_word carries the newly captured word, which stays on out_word until the next capture.
- R8: Every accepted word appears on out_word exactly once, in acceptance order and unmodified. This holds with a source clock faster than the destination clock and with one slower than it.
- R9: With both ports driven by the same clock, every load still inverts the toggle once and gives exactly one delivery, so R6 to R8 still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| ld_req | input | 1 | Request to load ld_word |
| ld_word | input | DW | Word to transfer |
| busy | output | 1 | Stability window active; new loads are dropped |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| out_word | output | DW | Last captured word |
| out_vld | output | 1 | One-cycle pulse marking a new out_word |

## Verification
The bench builds the block with an 8-bit word, a 3 ns worst-case source period and a 4 ns worst-case destination period. This gives HOLD_CYC = 7, which is short enough to count every busy cycle of every load. The destination runs at 4 ns against three source settings: 3 ns (faster), 7 ns (slower) and the destination clock itself (shared). In each setting a stream of arithmetic words is compared in order against the output. Dropped loads are placed both early in the busy window and in its last cycle, so the edges of the window are tested on every run.

// File: rtl/xwb_pkg.sv
`timescale 1ps/1ps
package xwb_pkg;
  // Source cycles needed to cover 3 destination periods plus one more for
  // phase uncertainty, plus one source cycle of margin.
  function automatic int min_hold(input int src_ps, input int dst_ps);
    return (4 * dst_ps + src_ps - 1) / src_ps + 1;
  endfunction
endpackage

// File: rtl/xwb_src.sv
`timescale 1ps/1ps
module xwb_src #(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_req,
  input  logic [DW-1:0] ld_word,
  output logic          busy,
  output logic          load_fire,
  output logic          tog,
  output logic [DW-1:0] hold_q
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] win_cnt;

  assign busy      = (win_cnt != '0);
  assign load_fire = ld_req & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      tog     <= 1'b0;
      hold_q  <= '0;
    end else if (load_fire) begin
      hold_q  <= ld_word;
      tog     <= ~tog;
      win_cnt <= CW'(HOLD_CYC);
    end else if (busy) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/xwb_sync.sv
`timescale 1ps/1ps
module xwb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_st
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst ? 1'b0 : d;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= rst ? 1'b0 : chain[g-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/xwb_dst.sv
`timescale 1ps/1ps
module xwb_dst #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tog_s,
  input  logic [DW-1:0] hold_q,
  output logic          cap_stb,
  output logic [DW-1:0] out_word,
  output logic          out_vld
);
  logic tog_d;
  assign cap_stb = tog_s ^ tog_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_d    <= 1'b0;
      out_word <= '0;
      out_vld  <= 1'b0;
    end else begin
      tog_d   <= tog_s;
      out_vld <= cap_stb;
      if (cap_stb) out_word <= hold_q;
    end
  end
endmodule

// File: rtl/xdom_word_bridge.sv
`timescale 1ps/1ps
module xdom_word_bridge #(
  parameter int DW         = 8,
  parameter int SRC_MIN_PS = 3000,
  parameter int DST_MAX_PS = 4000,
  parameter int HOLD_CYC   = xwb_pkg::min_hold(SRC_MIN_PS, DST_MAX_PS)
) (
  input  logic          src_clk,
  input  logic          src_rst,
  input  logic          ld_req,
  input  logic [DW-1:0] ld_word,
  output logic          busy,
  input  logic          dst_clk,
  input  logic          dst_rst,
  output logic [DW-1:0] out_word,
  output logic          out_vld
);
  logic          load_fire;
  logic          tog;
  logic [DW-1:0] hold_q;
  logic          tog_s;
  logic          cap_stb;

  xwb_src #(.DW(DW), .HOLD_CYC(HOLD_CYC)) u_src (
    .clk(src_clk), .rst(src_rst), .ld_req(ld_req), .ld_word(ld_word),
    .busy(busy), .load_fire(load_fire), .tog(tog), .hold_q(hold_q)
  );

  // toggle flop output feeds the first synchronizer flop directly
  xwb_sync #(.STAGES(2)) u_sync (
    .clk(dst_clk), .rst(dst_rst), .d(tog), .q(tog_s)
  );

  xwb_dst #(.DW(DW)) u_dst (
    .clk(dst_clk), .rst(dst_rst), .tog_s(tog_s), .hold_q(hold_q),
    .cap_stb(cap_stb), .out_word(out_word), .out_vld(out_vld)
  );
endmodule

// File: rtl/xwb_chk.sv
`timescale 1ps/1ps
module xwb_chk #(
  parameter int DW = 8
) (
  input logic          src_clk,
  input logic          src_rst,
  input logic          ld_req,
  input logic          busy,
  input logic          load_fire,
  input logic          tog,
  input logic [DW-1:0] hold_q,
  input logic          dst_clk,
  input logic          dst_rst,
  input logic          cap_stb,
  input logic          out_vld
);
  // R2
  load_flips_tog_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    load_fire |=> (tog != $past(tog)) && busy);
  // R4
  busy_req_ignored_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    (ld_req && busy) |=> $stable(tog));
  // R5
  hold_frozen_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    busy |=> $stable(hold_q));
  // R3
  busy_from_load_chk: assert property (@(posedge src_clk) disable iff (src_rst)
    $rose(busy) |-> $past(ld_req));
  // R6
  strobe_single_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    cap_stb |=> !cap_stb);
  // R7
  vld_after_stb_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    cap_stb |=> out_vld);
  // R7
  vld_one_cycle_chk: assert property (@(posedge dst_clk) disable iff (dst_rst)
    out_vld |=> !out_vld);
endmodule

bind xdom_word_bridge xwb_chk #(.DW(DW)) u_chk (
  .src_clk(src_clk), .src_rst(src_rst), .ld_req(ld_req), .busy(busy),
  .load_fire(load_fire), .tog(tog), .hold_q(hold_q),
  .dst_clk(dst_clk), .dst_rst(dst_rst), .cap_stb(cap_stb), .out_vld(out_vld)
);

// File: tb/sim_xdom_word_bridge.sv
`timescale 1ps/1ps
module sim_xdom_word_bridge;
  localparam int DW = 8;
  localparam int SRC_MIN = 3000;
  localparam int DST_MAX = 4000;
  localparam int HOLD = (4 * DST_MAX + SRC_MIN - 1) / SRC_MIN + 1;
  localparam int NW = 60;

  int checks = 0;
  int errors = 0;
  int s_half = 1500;
  int d_half = 2000;
  bit shared = 0;
  bit done = 0;

  logic sclk = 0, dclk = 0;
  logic src_rst = 1, dst_rst = 1;
  logic ld_req = 0;
  logic [DW-1:0] ld_word = '0;
  logic busy, out_vld;
  logic [DW-1:0] out_word;
  logic dst_clk;

  logic [DW-1:0] exp_q [0:255];
  int wr_i = 0, rd_i = 0;
  logic prev_vld = 0;
  string tag = "R8";

  always #(s_half) sclk = ~sclk;
  always #(d_half) dclk = ~dclk;
  assign dst_clk = shared ? sclk : dclk;

  xdom_word_bridge #(.DW(DW), .SRC_MIN_PS(SRC_MIN), .DST_MAX_PS(DST_MAX)) u0 (
    .src_clk(sclk), .src_rst(src_rst), .ld_req(ld_req), .ld_word(ld_word),
    .busy(busy), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .out_word(out_word), .out_vld(out_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // destination monitor
  always @(negedge dst_clk) begin
    if (!dst_rst && out_vld) begin
      chk(!prev_vld, "R7", prev_vld, 0);
      if (rd_i < wr_i) chk(out_word == exp_q[rd_i], tag, out_word, exp_q[rd_i]);
      else chk(0, "R1/R6 spurious valid", rd_i, wr_i);
      rd_i++;
    end
    prev_vld = out_vld;
  end

  task automatic do_load(input logic [DW-1:0] w, input int inj);
    int n;
    @(negedge sclk);
    ld_req = 1; ld_word = w;
    exp_q[wr_i] = w; wr_i++;
    @(negedge sclk);
    ld_req = 0;
    chk(busy === 1'b1, "R2", busy, 1);
    n = 0;
    while (busy === 1'b1 && n < 40) begin
      n++;
      // R4: junk request early in window or in its last cycle
      if ((inj == 1 && n == 2) || (inj == 2 && n == HOLD)) begin
        ld_req = 1; ld_word = ~w;
      end
      @(negedge sclk);
      ld_req = 0;
    end
    chk(n == HOLD, "R3", n, HOLD);
  endtask

  task automatic run_phase(input int sh, input int dh, input bit shr, input int seed);
    src_rst = 1; dst_rst = 1;
    s_half = sh; d_half = dh; shared = shr;
    repeat (4) @(negedge sclk);
    repeat (2) @(negedge dst_clk);
    chk(busy === 1'b0, "R1", busy, 0);
    chk(out_vld === 1'b0, "R1", out_vld, 0);
    chk(out_word === '0, "R1", out_word, 0);
    wr_i = 0; rd_i = 0;
    @(negedge sclk); src_rst = 0;
    @(negedge dst_clk); dst_rst = 0;
    repeat (10) @(negedge sclk);
    chk(rd_i == 0, "R1", rd_i, 0);
    for (int i = 0; i < NW; i++)
      do_load(DW'((i * 37 + seed * 11 + i / 7) & 8'hFF), i % 3);
    repeat (20) @(negedge dst_clk);
    // R6: one delivery per accepted load; R4: no junk delivered
    chk(rd_i == wr_i, tag, rd_i, wr_i);
  endtask

  initial begin
    tag = "R8"; run_phase(1500, 2000, 0, 1);  // faster source
    tag = "R8"; run_phase(3500, 2000, 0, 2);  // slower source
    tag = "R9"; run_phase(2000, 2000, 1, 3);  // shared clock
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150_000_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule